// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the serial bus controller of a small byte-wide nonvolatile memory and its storage array. The controller loads a word address once per write transaction and then presents each received data byte with a one-cycle strobe. The block keeps the upper address bits as the page row and the lower bits as a running position inside a sixteen-entry page buffer. The position wraps inside the page, so a seventeenth byte overwrites the first one. Each buffer entry carries a valid flag, which allows partial pages.

A stop strobe ends the transaction. If the page holds at least one byte and the write-protect input is low, the block enters a self-timed commit. It raises `busy`, scans the buffer in ascending order, and issues one array write for every flagged entry. It stays busy until a parameterised number of prescaled timer ticks has elapsed since the stop. Every bus-side strobe is ignored while `busy` is high, and the controller uses `busy` to withhold acknowledges. A start strobe that arrives before the stop discards the pending page.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0.
- R2: After `addr_ld` loads address A, the k-th accepted byte (k from 0) is stored at position (A[3:0]+k) mod 16. The commit writes it to array address {A[10:4], position} with the byte on `arr_data`, while `arr_we` is 1.
- R3: A page holding n < 16 distinct positions produces exactly n array writes, and no write to any other position.
- R4: With more than 16 bytes, the position wraps within the page. Exactly 16 writes follow, and each one carries the last byte sent to that position.
- R5: No array write and no `busy` occur before the stop strobe. `busy` is 1 in the cycle after an accepted stop.
- R6: `busy` falls one cycle after the WR_TICKS-th `tick` that is seen while busy. All array writes happen while `busy` is 1.
- R7: When `wp` is 1 in the stop cycle, no array write takes place, `busy` stays 0, and the page is discarded.
- R8: While `busy` is 1, the strobes `addr_ld`, `byte_stb`, `stop_stb` and `start_stb` have no effect. No byte is buffered, no new transaction is armed, and the cycle length is unchanged.
- R9: All valid flags clear when a commit finishes. A later page writes only its own bytes.
- R10: A `start_stb` after the address load and before the stop aborts the page. No write and no `busy` follow.
- R11: A `byte_stb` in the same cycle as an accepted `stop_stb` is part of the committed page.
- R12: A stop with no buffered byte (an address-only write) starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | Start condition seen on the bus |
| addr_ld | input | 1 | Load word address for a new write |
| addr_in | input | ADDR_W | Word address (row and page position) |
| byte_stb | input | 1 | Data byte received |
| byte_in | input | DATA_W | Received data byte |
| stop_stb | input | 1 | Valid stop condition seen |
| wp | input | 1 | Write protect, sampled with the stop |
| tick | input | 1 | Prescaled timer tick |
| busy | output | 1 | Self-timed write cycle running |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
A data byte and the stop strobe can fall in the same cycle. The final byte must then reach the buffer and the commit must still see its valid flag. The bench places a byte strobe on the stop cycle and checks that the extra position shows up among the array writes. The start and stop strobes can also collide with an active cycle. The bench fires every strobe during `busy` and judges the result by the number of writes, the tick count at the fall of `busy`, and the absence of a cycle for a following stop.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_COMMIT = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  valid_vec
);
  logic [DATA_W-1:0] mem [DEPTH];

  // plain synchronous write / registered read: maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)
        valid_vec[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        valid_vec[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int TICKS = 10,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             reached
);
  assign reached = (cnt == CNT_W'(TICKS));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick && !reached)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ROW_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_stb,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic              stop_stb,
  input  logic              wp,
  input  logic [DEPTH-1:0]  valid_vec,
  input  logic              reached,
  output logic              buf_wr_en,
  output logic [IDX_W-1:0]  buf_wr_idx,
  output logic              buf_clr,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              timer_run,
  output logic              armed,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr
);
  pwb_state_e       state, nxt;
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_act, scan_done, commit_go;
  logic             any_valid;

  assign any_valid  = |valid_vec;
  assign buf_wr_idx = ptr;
  assign rd_idx     = scan_idx;
  assign timer_run  = (state == ST_COMMIT);
  assign armed      = (state == ST_ARMED);

  always_comb begin
    nxt       = state;
    buf_wr_en = 1'b0;
    buf_clr   = 1'b0;
    commit_go = 1'b0;
    case (state)
      ST_IDLE: begin
        if (addr_ld) nxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (start_stb) begin
          buf_clr = 1'b1;
          nxt     = ST_IDLE;
        end else begin
          buf_wr_en = byte_stb;
          if (stop_stb) begin
            if (wp || !(any_valid || byte_stb)) begin
              buf_clr = 1'b1;
              nxt     = ST_IDLE;
            end else begin
              commit_go = 1'b1;
              nxt       = ST_COMMIT;
            end
          end
        end
      end
      ST_COMMIT: begin
        if (scan_done && reached) begin
          buf_clr = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      row       <= '0;
      ptr       <= '0;
      scan_idx  <= '0;
      scan_act  <= 1'b0;
      scan_done <= 1'b0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
    end else begin
      state <= nxt;
      busy  <= (nxt == ST_COMMIT);
      if (state == ST_IDLE && addr_ld) begin
        row <= addr_in[ADDR_W-1:IDX_W];
        ptr <= addr_in[IDX_W-1:0];
      end else if (buf_wr_en) begin
        ptr <= ptr + 1'b1;
      end
      if (commit_go) begin
        scan_idx  <= '0;
        scan_act  <= 1'b1;
        scan_done <= 1'b0;
        arr_we    <= 1'b0;
      end else if (scan_act) begin
        arr_we   <= valid_vec[scan_idx];
        arr_addr <= {row, scan_idx};
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == IDX_W'(DEPTH - 1)) begin
          scan_act  <= 1'b0;
          scan_done <= 1'b1;
        end
      end else begin
        arr_we <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_TICKS   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_stb,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_stb,
  input  logic              wp,
  input  logic              tick,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WR_TICKS + 1);

  logic                  buf_wr_en, buf_clr, timer_run, reached, armed;
  logic [IDX_W-1:0]      buf_wr_idx, rd_idx;
  logic [PAGE_BYTES-1:0] valid_vec;
  logic [CNT_W-1:0]      tick_cnt;

  pwb_ctrl #(.ADDR_W(ADDR_W), .DEPTH(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .start_stb(start_stb), .addr_ld(addr_ld),
    .addr_in(addr_in), .byte_stb(byte_stb), .stop_stb(stop_stb), .wp(wp),
    .valid_vec(valid_vec), .reached(reached), .buf_wr_en(buf_wr_en),
    .buf_wr_idx(buf_wr_idx), .buf_clr(buf_clr), .rd_idx(rd_idx),
    .timer_run(timer_run), .armed(armed), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr)
  );

  pwb_buffer #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .wr_en(buf_wr_en), .wr_idx(buf_wr_idx),
    .wr_data(byte_in), .clr(buf_clr), .rd_idx(rd_idx), .rd_data(arr_data),
    .valid_vec(valid_vec)
  );

  pwb_timer #(.TICKS(WR_TICKS)) u_timer (
    .clk(clk), .rst(rst), .run(timer_run), .tick(tick),
    .cnt(tick_cnt), .reached(reached)
  );
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W   = 11,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 4,
  parameter int WR_TICKS = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start_stb,
  input logic              stop_stb,
  input logic              byte_stb,
  input logic              wp,
  input logic              armed,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [CNT_W-1:0]  tick_cnt
);
  // R5
  commit_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !stop_stb) |=> !busy);
  // R6
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R6
  timed_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(tick_cnt) == CNT_W'(WR_TICKS)));
  // R7
  wp_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && wp && !busy) |=> !busy);
  // R10
  start_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (start_stb && !busy) |=> !busy);
  // R11
  stop_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && stop_stb && byte_stb && !wp && !start_stb) |=> busy);
  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> $stable(arr_addr[ADDR_W-1:IDX_W]));
endmodule

bind page_write_buffer pwb_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WR_TICKS(WR_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .start_stb(start_stb), .stop_stb(stop_stb),
  .byte_stb(byte_stb), .wp(wp), .armed(armed), .busy(busy),
  .arr_we(arr_we), .arr_addr(arr_addr), .tick_cnt(tick_cnt)
);

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int WT = 5;
  localparam int TICK_PER = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_stb = 1'b0, addr_ld = 1'b0, byte_stb = 1'b0, stop_stb = 1'b0;
  logic wp = 1'b0, tick = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_in = '0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0, fails = 0;
  int wr_cnt, tick_seen, row_bad, cycles = 0;
  logic busy_seen;
  logic [DW-1:0] got [PB];
  logic [PB-1:0] gotv;
  logic [DW-1:0] expd [PB];
  logic [PB-1:0] expv;
  int exp_row;
  int tdiv = 0;

  page_write_buffer #(.DATA_W(DW), .ADDR_W(AW), .PAGE_BYTES(PB), .WR_TICKS(WT)) u_dut (
    .clk(clk), .rst(rst), .start_stb(start_stb), .addr_ld(addr_ld),
    .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
    .stop_stb(stop_stb), .wp(wp), .tick(tick), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_PER - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_PER - 1);
  end

  always @(negedge clk) begin
    if (busy) busy_seen = 1'b1;
    if (arr_we) begin
      wr_cnt = wr_cnt + 1;
      got[arr_addr[3:0]] = arr_data;
      gotv[arr_addr[3:0]] = 1'b1;
      if (int'(arr_addr[AW-1:4]) != exp_row) row_bad = row_bad + 1;
    end
  end

  always @(posedge clk) if (tick && busy) tick_seen <= tick_seen + 1;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_obs(input int row);
    wr_cnt = 0; row_bad = 0; busy_seen = 1'b0; tick_seen = 0;
    gotv = '0; expv = '0; exp_row = row;
  endtask

  task automatic load(input int row, input int off);
    addr_in = AW'(row * PB + off); addr_ld = 1'b1; cyc(); addr_ld = 1'b0;
  endtask

  task automatic put(input logic [DW-1:0] d);
    byte_in = d; byte_stb = 1'b1; cyc(); byte_stb = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin cyc(); n++; end
  endtask

  task automatic check_page(input string req);
    int cnt = 0;
    for (int i = 0; i < PB; i++) if (expv[i]) cnt++;
    chk(req, wr_cnt, cnt);
    for (int i = 0; i < PB; i++) begin
      chk(req, int'(gotv[i]), int'(expv[i]));
      if (expv[i] && gotv[i]) chk(req, int'(got[i]), int'(expd[i]));
    end
    chk({req, " row"}, row_bad, 0);
  endtask

  task automatic run_page(input int row, input int off, input int n);
    clear_obs(row);
    load(row, off);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] d = DW'(row * 7 + i * 13 + n);
      expd[(off + i) % PB] = d; expv[(off + i) % PB] = 1'b1;
      put(d);
    end
    chk("R5 no busy before stop", int'(busy_seen), 0);
    chk("R5 no write before stop", wr_cnt, 0);
    tick_seen = 0;
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    chk("R5 busy after stop", int'(busy), 1);
    wait_idle();
    chk("R6 ticks at busy fall", tick_seen, WT);
    cyc();
    if (n > PB) check_page("R4 wrap"); else check_page("R3 partial R2 place");
  endtask

  task automatic expect_no_cycle(input string req);
    for (int i = 0; i < 40; i++) cyc();
    chk({req, " busy"}, int'(busy_seen), 0);
    chk({req, " writes"}, wr_cnt, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 we reset", int'(arr_we), 0);

    // R2 R3 R4 sweep of lengths and start offsets
    for (int n = 1; n <= 20; n++) run_page(n * 3 % 128, (n * 5) % PB, n);

    // R9 small page after full pages
    run_page(9, 14, 3);
    chk("R9 only own bytes", wr_cnt, 3);

    // R7 write protect
    clear_obs(4); load(4, 0); put(8'h11); put(8'h22);
    wp = 1'b1; stop_stb = 1'b1; cyc(); stop_stb = 1'b0; wp = 1'b0;
    expect_no_cycle("R7 protect");
    clear_obs(4); stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    expect_no_cycle("R7 page discarded");

    // R10 start aborts
    clear_obs(5); load(5, 2); put(8'hA1); put(8'hA2); put(8'hA3);
    start_stb = 1'b1; cyc(); start_stb = 1'b0;
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    expect_no_cycle("R10 abort");

    // R12 address only
    clear_obs(6); load(6, 7);
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    expect_no_cycle("R12 addr only");

    // R11 byte coincident with stop
    clear_obs(7); load(7, 15);
    put(8'h5A); expd[15] = 8'h5A; expv[15] = 1'b1;
    put(8'h6B); expd[0] = 8'h6B; expv[0] = 1'b1;
    byte_in = 8'h7C; expd[1] = 8'h7C; expv[1] = 1'b1;
    byte_stb = 1'b1; stop_stb = 1'b1; tick_seen = 0; cyc();
    byte_stb = 1'b0; stop_stb = 1'b0;
    chk("R11 busy", int'(busy), 1);
    wait_idle(); cyc();
    check_page("R11 stop byte");

    // R8 strobes during busy are ignored
    clear_obs(8); load(8, 4);
    put(8'h01); expd[4] = 8'h01; expv[4] = 1'b1;
    put(8'h02); expd[5] = 8'h02; expv[5] = 1'b1;
    tick_seen = 0;
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    cyc(); cyc();
    load(8, 9); put(8'hEE); put(8'hEF);
    start_stb = 1'b1; cyc(); start_stb = 1'b0;
    for (int i = 0; i < 30; i++) cyc();
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    wait_idle();
    chk("R8 cycle length", tick_seen, WT);
    cyc();
    check_page("R8 ignored");
    clear_obs(8);
    stop_stb = 1'b1; cyc(); stop_stb = 1'b0;
    expect_no_cycle("R8 not armed");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule